// File: doc/BRIEF.md
# Flash Hardware-Reset and Ready/Busy Sequencer

This block sits beside the command state machine of a NOR-style flash memory model. It screens the active-low hardware reset pin and accepts a reset only when the pin stays low long enough. It then issues a one-cycle internal reset to the command logic and keeps the read and write bus gated until the part has recovered. It also drives the ready/busy line as an open-drain output: the line is pulled low while a program or erase runs and is released otherwise.

A supply-lockout flag blocks command writes. If the flag rises while an operation is running, that operation is aborted and the touched data is flagged as invalid. The flag clears on the next accepted hardware reset. Every duration is counted in clock cycles. The reset pin is asynchronous and passes through a synchroniser of `SYNC_STAGES` flops before anything else sees it.

Top module: `flash_rstbusy_ctrl`

## Requirements
- R1: After the system reset, `bus_en`=1 and `rb_oe`=0, `core_reset`=0, `pe_abort`=0 and `data_bad`=0.
- R2: A low on `reset_pin_n` that is seen on fewer than `HOLD_CYC` consecutive clock samples produces no `core_reset` pulse and leaves `bus_en` high.
- R3: A low that is seen on `HOLD_CYC` consecutive samples gives exactly one `core_reset` pulse, one cycle wide. The pulse appears two edges after the last of those samples. `bus_en` drops in the same cycle as the pulse.
- R4: Once the synchronised pin is high again, `bus_en` stays low for a further `max(REC_A_CYC, REC_B_CYC)` cycles at least.
- R5: When the recovery time has run out, `bus_en` returns only in the cycle after `rb_oe` is seen low. `rd_go` = `rd_req` AND `bus_en`.
- R6: `rb_oe` goes high one cycle after `pe_busy` is 1 with `op_mode` = 3 (program/erase running). It is released for modes 0 (read), 1 (auto-select) and 2 (erase suspend), whatever `pe_busy` is. `rb_dat` is always 0.
- R7: While `lockout` is 1, `wr_go` is 0. Reads are not affected.
- R8: When `lockout` is 1 during a running operation, `pe_abort` is high in the next cycle and `data_bad` is set. `data_bad` stays set after `lockout` falls.
- R9: The cycle after a `core_reset` pulse, `data_bad` is 0, unless an abort is set in that same cycle.
- R10: Several devices can share one pulled-up ready/busy line, which reads low whenever any of their output enables is high.
- R11: A low sample on the synchronised pin while the bus is gated restarts the recovery once the pin is high again. It gives no further `core_reset` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| reset_pin_n | input | 1 | Asynchronous hardware reset pin, active low |
| pe_busy | input | 1 | Program/erase engine is busy |
| op_mode | input | 2 | 0 read, 1 auto-select, 2 erase suspend, 3 program/erase running |
| lockout | input | 1 | Supply-lockout flag |
| rd_req | input | 1 | Bus read request |
| wr_req | input | 1 | Bus write (command) request |
| rb_oe | output | 1 | Ready/busy pull-low enable |
| rb_dat | output | 1 | Ready/busy data value, constant 0 |
| core_reset | output | 1 | One-cycle internal reset for the command logic |
| bus_en | output | 1 | Bus operations allowed |
| rd_go | output | 1 | Read request passed to the array |
| wr_go | output | 1 | Write request passed to the command logic |
| pe_abort | output | 1 | Abort the running program/erase |
| data_bad | output | 1 | Sticky flag: aborted data is invalid |

## Verification
Every registered result is due a fixed number of edges after its cause. `core_reset` arrives `SYNC_STAGES` edges after the last qualifying sample. `rb_oe`, `pe_abort` and `data_bad` follow their inputs by one edge. `bus_en` returns one edge after `rb_oe` falls, once the recovery window has elapsed. `rd_go` and `wr_go` follow their inputs in the same cycle. A behavioural reference model in the bench counts those same edges from its inputs. Both model and design are compared on the falling clock edge, and stimulus changes only just after it, so every comparison sees settled values for the cycle in question.

// File: rtl/flash_rb_pkg.sv
// Package: shared types for the flash reset / ready-busy sequencer.
// Assumes: op_mode encoding is fixed by the command state machine.
package flash_rb_pkg;

    // Gate sequencing states
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,  // bus open
        ST_HOLD     = 2'd1,  // reset accepted, pin still low
        ST_RECOVER  = 2'd2,  // counting the recovery window
        ST_WAIT_RDY = 2'd3   // waiting for ready/busy release
    } frb_state_t;

    // Operating modes reported by the command state machine
    typedef enum logic [1:0] {
        OPM_READ     = 2'd0,
        OPM_AUTOSEL  = 2'd1,
        OPM_SUSPEND  = 2'd2,
        OPM_PROGERAS = 2'd3
    } frb_mode_t;

    // Longer of two recovery intervals
    function automatic int unsigned frb_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/frb_pin_filter.sv
// Module: frb_pin_filter
// Synchronises the asynchronous reset pin and measures how long it stays low
// with a saturating counter. hold_met flags the sample that completes
// HOLD_CYC consecutive low samples.
// Assumes: SYNC_STAGES >= 1, HOLD_CYC >= 1.
module frb_pin_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYC    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_low_s,
    output logic hold_met
);

    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt;

    // Synchroniser chain, one flop per stage
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // First stage samples the pad
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= pin_n;
                end
            end else begin : g_next
                // Later stages shift the sampled value along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b1;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_low_s = ~sync_q[SYNC_STAGES-1];

    // Saturating count of consecutive low samples
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_cnt <= '0;
        else if (!pin_low_s)                 low_cnt <= '0;
        else if (low_cnt != CNT_W'(HOLD_CYC)) low_cnt <= low_cnt + 1'b1;
    end

    assign hold_met = pin_low_s && (low_cnt == CNT_W'(HOLD_CYC - 1));

endmodule

// File: rtl/frb_recovery.sv
// Module: frb_recovery
// Counts the recovery window after the reset pin is released. The count
// restarts whenever run drops. done is high on the last cycle of the window.
// Assumes: REC_CYC >= 1.
module frb_recovery #(
    parameter int unsigned REC_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(REC_CYC + 1);

    logic [CNT_W-1:0] rec_cnt;

    // Count cycles while run is held; clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    rec_cnt <= '0;
        else if (!run) rec_cnt <= '0;
        else if (done) rec_cnt <= '0;
        else           rec_cnt <= rec_cnt + 1'b1;
    end

    assign done = run && (rec_cnt == CNT_W'(REC_CYC - 1));

endmodule

// File: rtl/frb_rb_drive.sv
// Module: frb_rb_drive
// Drives the open-drain ready/busy output, raises the abort request when
// lockout hits a running operation, and keeps the sticky invalid-data flag.
// Assumes: op_mode 3 means program/erase in progress; clr is the internal
// reset pulse. Setting the flag takes priority over clearing it.
module frb_rb_drive
    import flash_rb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pe_busy,
    input  logic [1:0] op_mode,
    input  logic       lockout,
    input  logic       clr,
    output logic       rb_oe,
    output logic       pe_abort,
    output logic       data_bad
);

    logic running;
    logic kill;

    assign running = pe_busy && (op_mode == OPM_PROGERAS);
    assign kill    = running && lockout;

    // Pull the shared line low while an operation runs
    always_ff @(posedge clk) begin
        if (!rst_n) rb_oe <= 1'b0;
        else        rb_oe <= running;
    end

    // Abort request to the program/erase engine
    always_ff @(posedge clk) begin
        if (!rst_n) pe_abort <= 1'b0;
        else        pe_abort <= kill;
    end

    // Sticky invalid-data flag, cleared by the internal reset
    always_ff @(posedge clk) begin
        if (!rst_n)    data_bad <= 1'b0;
        else if (kill) data_bad <= 1'b1;
        else if (clr)  data_bad <= 1'b0;
    end

endmodule

// File: rtl/flash_rstbusy_ctrl.sv
// Module: flash_rstbusy_ctrl (top)
// Accepts a hardware reset only after a long enough low on the pin and
// pulses core_reset once. It gates the bus until the pin is released, the
// longer recovery interval has passed and ready/busy is released. It also
// drives ready/busy and handles supply lockout.
// Assumes: inputs other than reset_pin_n are synchronous to clk.
module flash_rstbusy_ctrl
    import flash_rb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYC    = 8,
    parameter int unsigned REC_A_CYC   = 12,
    parameter int unsigned REC_B_CYC   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reset_pin_n,
    input  logic       pe_busy,
    input  logic [1:0] op_mode,
    input  logic       lockout,
    input  logic       rd_req,
    input  logic       wr_req,
    output logic       rb_oe,
    output logic       rb_dat,
    output logic       core_reset,
    output logic       bus_en,
    output logic       rd_go,
    output logic       wr_go,
    output logic       pe_abort,
    output logic       data_bad
);

    localparam int unsigned REC_CYC = frb_max(REC_A_CYC, REC_B_CYC);

    frb_state_t state, state_nx;
    logic       pin_low_s;
    logic       hold_met;
    logic       rec_run;
    logic       rec_done;
    logic       accept;

    frb_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CYC    (HOLD_CYC)
    ) i_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (reset_pin_n),
        .pin_low_s (pin_low_s),
        .hold_met  (hold_met)
    );

    assign rec_run = (state == ST_RECOVER) && !pin_low_s;

    frb_recovery #(
        .REC_CYC (REC_CYC)
    ) i_recovery (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rec_run),
        .done  (rec_done)
    );

    frb_rb_drive i_rbdrv (
        .clk      (clk),
        .rst_n    (rst_n),
        .pe_busy  (pe_busy),
        .op_mode  (op_mode),
        .lockout  (lockout),
        .clr      (core_reset),
        .rb_oe    (rb_oe),
        .pe_abort (pe_abort),
        .data_bad (data_bad)
    );

    assign accept = (state == ST_RUN) && hold_met;

    // Next-state decode for the bus gate
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:      if (hold_met) state_nx = ST_HOLD;
            ST_HOLD:     if (!pin_low_s) state_nx = ST_RECOVER;
            ST_RECOVER:  if (pin_low_s) state_nx = ST_HOLD;
                         else if (rec_done) state_nx = ST_WAIT_RDY;
            ST_WAIT_RDY: if (pin_low_s) state_nx = ST_HOLD;
                         else if (!rb_oe) state_nx = ST_RUN;
            default:     state_nx = ST_HOLD;
        endcase
    end

    // Gate state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // One-cycle internal reset on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) core_reset <= 1'b0;
        else        core_reset <= accept;
    end

    assign bus_en = (state == ST_RUN);
    assign rd_go  = rd_req && bus_en;
    assign wr_go  = wr_req && bus_en && !lockout;
    assign rb_dat = 1'b0;

endmodule

// File: rtl/frb_checker.sv
// Module: frb_checker
// Temporal properties of flash_rstbusy_ctrl, attached by bind.
module frb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pe_busy,
    input logic [1:0] op_mode,
    input logic       lockout,
    input logic       rb_oe,
    input logic       rb_dat,
    input logic       core_reset,
    input logic       bus_en,
    input logic       wr_go,
    input logic       pe_abort,
    input logic       data_bad
);

    // R3
    core_reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |=> !core_reset);

    // R3
    core_reset_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |-> !bus_en);

    // R5
    busy_keeps_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_oe && !bus_en) |=> !bus_en);

    // R6
    rb_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_oe |-> ($past(pe_busy) && $past(op_mode) == 2'd3));

    // R6
    rb_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_dat);

    // R7
    lockout_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !wr_go);

    // R8
    abort_marks_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_abort |-> data_bad);

    // R9
    reset_clears_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |=> (pe_abort || !data_bad));

endmodule

bind flash_rstbusy_ctrl frb_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pe_busy    (pe_busy),
    .op_mode    (op_mode),
    .lockout    (lockout),
    .rb_oe      (rb_oe),
    .rb_dat     (rb_dat),
    .core_reset (core_reset),
    .bus_en     (bus_en),
    .wr_go      (wr_go),
    .pe_abort   (pe_abort),
    .data_bad   (data_bad)
);

// File: tb/test_flash_rstbusy_ctrl.sv
// Bench: behavioural reference model compared every falling edge,
// plus directed checks on pulse counts and the shared busy line.
module test_flash_rstbusy_ctrl;

    localparam int SYNC = 2;
    localparam int HOLD = 8;
    localparam int RECA = 12;
    localparam int RECB = 20;
    localparam int REC  = (RECA > RECB) ? RECA : RECB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reset_pin_n = 1'b1;
    logic       pe_busy = 1'b0;
    logic [1:0] op_mode = 2'd0;
    logic       lockout = 1'b0;
    logic       rd_req = 1'b0;
    logic       wr_req = 1'b0;
    logic       peer_oe = 1'b0;
    logic       rb_oe, rb_dat, core_reset, bus_en, rd_go, wr_go, pe_abort, data_bad;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int cycles = 0;

    flash_rstbusy_ctrl #(
        .SYNC_STAGES (SYNC), .HOLD_CYC (HOLD), .REC_A_CYC (RECA), .REC_B_CYC (RECB)
    ) i_flash_rstbusy_ctrl (
        .clk (clk), .rst_n (rst_n), .reset_pin_n (reset_pin_n), .pe_busy (pe_busy),
        .op_mode (op_mode), .lockout (lockout), .rd_req (rd_req), .wr_req (wr_req),
        .rb_oe (rb_oe), .rb_dat (rb_dat), .core_reset (core_reset), .bus_en (bus_en),
        .rd_go (rd_go), .wr_go (wr_go), .pe_abort (pe_abort), .data_bad (data_bad)
    );

    always #4 clk = ~clk;

    // Pull-up model of a line shared with a second device
    wire shared_line = !(rb_oe || peer_oe);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Reference model state
    int m_sync[SYNC];
    int m_low, m_phase, m_rec, m_oe, m_rst, m_abort, m_bad;

    // Reference model: advances on each rising edge from the settled inputs
    always @(posedge clk) begin
        int ps_low, n_low, n_phase, n_rec, run, kill;
        if (!rst_n) begin
            foreach (m_sync[i]) m_sync[i] = 1;
            m_low = 0; m_phase = 0; m_rec = 0;
            m_oe = 0; m_rst = 0; m_abort = 0; m_bad = 0;
        end else begin
            ps_low = (m_sync[SYNC-1] == 0);
            for (int i = SYNC-1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = reset_pin_n;
            n_low = ps_low ? ((m_low < HOLD) ? m_low + 1 : HOLD) : 0;
            n_phase = m_phase; n_rec = m_rec;
            if (m_phase == 0) begin
                n_phase = (ps_low && m_low == HOLD - 1) ? 1 : 0;
            end else if (ps_low) begin
                n_phase = 1; n_rec = 0;
            end else if (m_phase == 1) begin
                n_phase = 2; n_rec = 0;
            end else if (m_phase == 2) begin
                if (m_rec == REC - 1) begin n_phase = 3; n_rec = 0; end
                else n_rec = m_rec + 1;
            end else if (m_oe == 0) begin
                n_phase = 0;
            end
            run  = (pe_busy && op_mode == 2'd3) ? 1 : 0;
            kill = (run && lockout) ? 1 : 0;
            m_bad   = kill ? 1 : (m_rst ? 0 : m_bad);
            m_rst   = (m_phase == 0 && ps_low && m_low == HOLD - 1) ? 1 : 0;
            m_oe    = run;
            m_abort = kill;
            m_low = n_low; m_phase = n_phase; m_rec = n_rec;
        end
    end

    // Per-cycle comparison on the falling edge, plus watchdog
    always @(negedge clk) begin
        int ben;
        cycles++;
        if (rst_n) begin
            ben = (m_phase == 0) ? 1 : 0;
            check("R3 core_reset", core_reset, m_rst);
            check("R4 bus_en", bus_en, ben);
            check("R5 rd_go", rd_go, (rd_req && ben) ? 1 : 0);
            check("R6 rb_oe", rb_oe, m_oe);
            check("R6 rb_dat", rb_dat, 0);
            check("R7 wr_go", wr_go, (wr_req && ben && !lockout) ? 1 : 0);
            check("R8 pe_abort", pe_abort, m_abort);
            check("R9 data_bad", data_bad, m_bad);
            if (core_reset) pulses++;
        end
        if (cycles > 20000) begin
            check("watchdog", 1, 0);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pin_low(input int n);
        reset_pin_n = 1'b0;
        step(n);
        reset_pin_n = 1'b1;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 bus_en", bus_en, 1);
        check("R1 rb_oe", rb_oe, 0);
        check("R1 core_reset", core_reset, 0);
        check("R1 pe_abort", pe_abort, 0);
        check("R1 data_bad", data_bad, 0);

        // R2 short pulse, one sample short
        pin_low(HOLD - 1);
        step(10);
        check("R2 pulses", pulses, 0);
        check("R2 bus_en", bus_en, 1);

        // R3 long pulse
        pin_low(HOLD + 4);
        step(8);
        check("R3 pulses", pulses, 1);
        check("R4 gated mid-recovery", bus_en, 0);
        // R11 glitch during recovery
        pin_low(2);
        step(REC);
        check("R11 still gated", bus_en, 0);
        check("R11 pulses", pulses, 1);

        // R5 busy holds the gate after recovery
        op_mode = 2'd3; pe_busy = 1'b1; rd_req = 1'b1;
        step(30);
        check("R5 gated while busy", bus_en, 0);
        check("R5 rd_go blocked", rd_go, 0);
        pe_busy = 1'b0;
        step(3);
        check("R5 open after release", bus_en, 1);
        check("R5 rd_go", rd_go, 1);

        // R6 modes with busy set
        pe_busy = 1'b1;
        for (int md = 0; md < 4; md++) begin
            op_mode = 2'(md);
            step(2);
            check("R6 mode", rb_oe, (md == 3) ? 1 : 0);
        end

        // R10 shared line with a peer device
        op_mode = 2'd0;
        for (int p = 0; p < 2; p++) begin
            for (int own = 0; own < 2; own++) begin
                op_mode = own ? 2'd3 : 2'd0;
                peer_oe = p[0];
                step(2);
                check("R10 line", shared_line ? 1 : 0, (p == 0 && own == 0) ? 1 : 0);
            end
        end
        peer_oe = 1'b0;

        // R7 lockout while idle
        op_mode = 2'd0; wr_req = 1'b1;
        step(2);
        check("R7 wr_go open", wr_go, 1);
        lockout = 1'b1;
        step(1);
        check("R7 wr_go blocked", wr_go, 0);
        check("R7 rd_go kept", rd_go, 1);
        check("R8 no abort idle", pe_abort, 0);

        // R8 lockout during a running operation
        op_mode = 2'd3;
        step(2);
        check("R8 abort", pe_abort, 1);
        check("R8 bad", data_bad, 1);
        lockout = 1'b0; pe_busy = 1'b0; op_mode = 2'd0;
        step(5);
        check("R8 sticky", data_bad, 1);

        // R9 hardware reset clears the flag
        pin_low(HOLD + 2);
        step(REC + 10);
        check("R9 cleared", data_bad, 0);
        check("R3 second pulse", pulses, 2);
        check("R5 reopened", bus_en, 1);
        step(4);
        finish_run();
    end

endmodule